// File: doc/BRIEF.md
# Serial Channel Register and Interrupt Controller

This block is the register front end of an asynchronous serial channel. A host reaches eight byte-wide registers through a simple single-byte read/write bus. The block holds one transmit byte and one receive byte. It tracks when the transmit data register is empty and when the transmitter has gone idle, and it flags a full receive register and overruns. It drives four interrupts: a transmit pulse, a transmit-end level, a receive pulse and an error level. The bit-level frame engine sits beside it. The block hands that engine one byte per launch strobe and learns of finished frames, received bytes and line breaks through single-cycle strobes.

A byte written while the transmitter is idle goes out at once. A byte written while a frame is in flight waits in the data register and is chained when that frame ends. Error flags are cleared by reading the status register and then writing zeros to its error bits. The mode register bits for parity, multiprocessor operation and smart-card operation are stored and read back, but they have no effect. The frame-engine links carry no back-pressure. A launch strobe must be taken by the engine in the cycle it appears. A received byte is always accepted: if the receive register is still full, the byte is dropped and overrun is flagged instead.

Top module: `sci_regif`

## Requirements
- R1: After reset, mode, control, smart-card and extended registers read 0x00, bit rate 0xFF, transmit data 0xFF, receive data 0x00, status 0x84, and all four interrupts and the launch strobe are low.
- R2: Register offsets are mode 0, bit rate 1, control 2, transmit data 3, status 4, receive data 5, smart-card 6, extended 7. Writes to mode and bit rate are ignored while control bit 5 (transmit enable) or bit 4 (receive enable) is 1. Otherwise all writable registers read back what was written.
- R3: Status bits are 7 transmit empty, 6 receive full, 5 overrun, 4 framing error, 3 parity error, 2 transmit end, 1 reads 0, 0 multiprocessor transfer. A control write with bit 5 set forces bits 7 and 2 to 1 and, if control bit 7 (transmit interrupt enable) is in the written value, pulses irq_tx for one cycle.
- R4: A transmit-data write while transmit end is 1 raises tx_start for one cycle, one cycle later, with tx_byte equal to the written value. It clears transmit end, sets transmit empty, drops irq_tend, and pulses irq_tx if control bit 7 is set.
- R5: A transmit-data write while transmit end is 0 only stores the byte and clears transmit empty. There is no launch.
- R6: On frame_done, a queued byte (transmit empty 0) is launched as in R4. Otherwise transmit end is set, and irq_tend goes high and stays high if control bit 2 (transmit-end interrupt enable) is set.
- R7: With control bit 4 set and receive full clear, rx_valid stores rx_data, sets receive full, and pulses irq_rx if control bit 6 (receive interrupt enable) is set. With bit 4 clear, received bytes are ignored.
- R8: A byte that arrives while receive full is set is dropped. It sets overrun and raises irq_err if control bit 6 is set. Reading receive data clears receive full.
- R9: A status write changes only bit 0 and bits 5:3. irq_err drops when the most recent status read showed an error bit and the write leaves all three error bits zero.
- R10: rx_break sets the framing error bit and raises irq_err if control bit 6 is set.
- R11: A control write with bit 2 clear drops irq_tend, and one with bit 6 clear drops irq_err. Writes to the receive data register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| tx_start | output | 1 | One-cycle launch strobe to the frame engine |
| tx_byte | output | 8 | Byte being launched, held until the next launch |
| frame_done | input | 1 | One-cycle end-of-frame strobe from the frame engine |
| rx_valid | input | 1 | One-cycle received-byte strobe |
| rx_data | input | 8 | Received byte, valid with rx_valid |
| rx_break | input | 1 | One-cycle line-break indication |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_tend | output | 1 | Transmit-end interrupt level |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_err | output | 1 | Error interrupt level |

## Verification
A wrong transmit-end or transmit-empty flag shows up as a wrong launch decision. Either a byte leaves on tx_start one cycle after a write that should have queued it, or a queued byte never appears after frame_done. The transmit scoreboard catches both at the next launch. A wrong receive-full or error state shows up in the status byte and on irq_rx or irq_err one cycle after the strobe that caused it. The bench reads status back right after each event, so such a fault is caught within a few cycles.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int EW = 3;

  typedef enum logic [AW-1:0] {
    OFS_MODE = 3'd0,
    OFS_RATE = 3'd1,
    OFS_CTRL = 3'd2,
    OFS_TDAT = 3'd3,
    OFS_STAT = 3'd4,
    OFS_RDAT = 3'd5,
    OFS_SMC  = 3'd6,
    OFS_EXT  = 3'd7
  } reg_ofs_e;

  // control bit positions
  localparam int C_TEIE = 2;
  localparam int C_RE   = 4;
  localparam int C_TE   = 5;
  localparam int C_RIE  = 6;
  localparam int C_TIE  = 7;

  // status bit positions
  localparam int S_MPBT = 0;
  localparam int S_ELO  = 3;

  // error vector indices
  localparam int E_PAR = 0;
  localparam int E_FRM = 1;
  localparam int E_OVR = 2;

  localparam logic [DW-1:0] RST_ZERO = 8'h00;
  localparam logic [DW-1:0] RST_RATE = 8'hFF;
  localparam logic [DW-1:0] RST_TDAT = 8'hFF;
endpackage

// File: rtl/sci_cfg_regs.sv
module sci_cfg_regs
  import sci_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_mode,
  input  logic          wr_rate,
  input  logic          wr_ctrl,
  input  logic          wr_smc,
  input  logic          wr_ext,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] rate_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] smc_q,
  output logic [DW-1:0] ext_q
);
  logic locked;
  assign locked = ctrl_q[C_TE] | ctrl_q[C_RE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= RST_ZERO;
      rate_q <= RST_RATE;
      ctrl_q <= RST_ZERO;
      smc_q  <= RST_ZERO;
      ext_q  <= RST_ZERO;
    end else begin
      if (wr_mode && !locked) mode_q <= wdata;
      if (wr_rate && !locked) rate_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata;
      if (wr_smc)  smc_q  <= wdata;
      if (wr_ext)  ext_q  <= wdata;
    end
  end

  // R2: framing setup frozen while a direction is enabled
  a_r2_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(mode_q) && $stable(rate_q));
endmodule

// File: rtl/sci_tx_ctrl.sv
module sci_tx_ctrl
  import sci_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_tdat,
  input  logic [DW-1:0] wdata,
  input  logic          tie,
  input  logic          teie,
  input  logic          frame_done,
  output logic [DW-1:0] tdat_q,
  output logic          tx_empty,
  output logic          tx_end,
  output logic          tx_start,
  output logic [DW-1:0] tx_byte,
  output logic          irq_tx,
  output logic          irq_tend
);
  logic          end_n, empty_n, launch, tend_set, tend_n;
  logic [DW-1:0] lbyte;
  logic          ctl_te;
  assign ctl_te = wr_ctrl & wdata[C_TE];

  always_comb begin
    end_n    = tx_end;
    empty_n  = tx_empty;
    launch   = 1'b0;
    lbyte    = tdat_q;
    tend_set = 1'b0;
    // end-of-frame is resolved before a coincident data write
    if (frame_done) begin
      if (!tx_empty) begin
        launch  = 1'b1;
        end_n   = 1'b0;
        empty_n = 1'b1;
      end else begin
        end_n    = 1'b1;
        tend_set = 1'b1;
      end
    end
    if (wr_tdat) begin
      if (end_n) begin
        launch   = 1'b1;
        lbyte    = wdata;
        end_n    = 1'b0;
        empty_n  = 1'b1;
        tend_set = 1'b0;
      end else begin
        empty_n = 1'b0;
      end
    end
    if (ctl_te) begin
      end_n   = 1'b1;
      empty_n = 1'b1;
    end
    tend_n = irq_tend;
    if (tend_set && teie) tend_n = 1'b1;
    if (launch) tend_n = 1'b0;
    if (wr_ctrl && !wdata[C_TEIE]) tend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdat_q   <= RST_TDAT;
      tx_empty <= 1'b1;
      tx_end   <= 1'b1;
      tx_start <= 1'b0;
      tx_byte  <= RST_ZERO;
      irq_tx   <= 1'b0;
      irq_tend <= 1'b0;
    end else begin
      if (wr_tdat) tdat_q <= wdata;
      tx_empty <= empty_n;
      tx_end   <= end_n;
      tx_start <= launch;
      if (launch) tx_byte <= lbyte;
      irq_tx   <= (launch & tie) | (ctl_te & wdata[C_TIE]);
      irq_tend <= tend_n;
    end
  end

  // R6: transmit-end level only while the transmitter is idle
  a_r6_tend_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tend |-> tx_end);
  // R5: a write during a frame leaves the byte queued
  a_r5_write_queues: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tdat && !tx_end && !frame_done) |=> !tx_empty && !tx_start);
  // R4: a write to an idle transmitter launches next cycle
  a_r4_idle_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tdat && tx_end && !frame_done) |=> tx_start && !tx_end);
endmodule

// File: rtl/sci_rx_ctrl.sv
module sci_rx_ctrl
  import sci_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          rie_new,
  input  logic          wr_stat,
  input  logic          wr_mpbt,
  input  logic [EW-1:0] wr_err,
  input  logic          rd_stat,
  input  logic          rd_rdat,
  input  logic          re,
  input  logic          rie,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  output logic [DW-1:0] rdat_q,
  output logic          rx_full,
  output logic [EW-1:0] err_q,
  output logic          mpbt_q,
  output logic          irq_rx,
  output logic          irq_err
);
  logic          full_eff, accept, store, ovr;
  logic [EW-1:0] err_n, seen_q;
  logic          ierr_n;

  assign full_eff = rx_full & ~rd_rdat;
  assign accept   = rx_valid & re;
  assign store    = accept & ~full_eff;
  assign ovr      = accept & full_eff;

  always_comb begin
    err_n = wr_stat ? wr_err : err_q;
    if (ovr)      err_n[E_OVR] = 1'b1;
    if (rx_break) err_n[E_FRM] = 1'b1;
    ierr_n = irq_err;
    if (wr_stat && (|seen_q) && (wr_err == '0)) ierr_n = 1'b0;
    if ((ovr || rx_break) && rie) ierr_n = 1'b1;
    if (wr_ctrl && !rie_new) ierr_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdat_q  <= RST_ZERO;
      rx_full <= 1'b0;
      err_q   <= '0;
      seen_q  <= '0;
      mpbt_q  <= 1'b0;
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      if (store) rdat_q <= rx_data;
      rx_full <= full_eff | store;
      err_q   <= err_n;
      if (rd_stat) seen_q <= err_q;
      if (wr_stat) mpbt_q <= wr_mpbt;
      irq_rx  <= store & rie;
      irq_err <= ierr_n;
    end
  end

  // R7: receive pulse accompanies a full receive register
  a_r7_rx_pulse_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_full);
  // R11: error level needs its enable
  a_r11_err_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> rie);
  // R8: overrun keeps the stored byte
  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> $stable(rdat_q) && err_q[E_OVR]);
endmodule

// File: rtl/sci_regif.sv
module sci_regif
  import sci_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_start,
  output logic [DW-1:0] tx_byte,
  input  logic          frame_done,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_break,
  output logic          irq_tx,
  output logic          irq_tend,
  output logic          irq_rx,
  output logic          irq_err
);
  reg_ofs_e      ofs;
  logic [DW-1:0] wsel, rsel;
  logic [DW-1:0] mode_q, rate_q, ctrl_q, smc_q, ext_q, tdat_q, rdat_q, stat;
  logic          tx_empty, tx_end, rx_full, mpbt_q;
  logic [EW-1:0] err_q;

  assign ofs = reg_ofs_e'(bus_addr);

  for (genvar g = 0; g < DW; g++) begin : g_dec
    assign wsel[g] = bus_en &  bus_wr & (bus_addr == AW'(g));
    assign rsel[g] = bus_en & ~bus_wr & (bus_addr == AW'(g));
  end

  sci_cfg_regs i_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_mode(wsel[OFS_MODE]),
    .wr_rate(wsel[OFS_RATE]),
    .wr_ctrl(wsel[OFS_CTRL]),
    .wr_smc (wsel[OFS_SMC]),
    .wr_ext (wsel[OFS_EXT]),
    .wdata  (bus_wdata),
    .mode_q (mode_q),
    .rate_q (rate_q),
    .ctrl_q (ctrl_q),
    .smc_q  (smc_q),
    .ext_q  (ext_q)
  );

  sci_tx_ctrl i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wsel[OFS_CTRL]),
    .wr_tdat   (wsel[OFS_TDAT]),
    .wdata     (bus_wdata),
    .tie       (ctrl_q[C_TIE]),
    .teie      (ctrl_q[C_TEIE]),
    .frame_done(frame_done),
    .tdat_q    (tdat_q),
    .tx_empty  (tx_empty),
    .tx_end    (tx_end),
    .tx_start  (tx_start),
    .tx_byte   (tx_byte),
    .irq_tx    (irq_tx),
    .irq_tend  (irq_tend)
  );

  sci_rx_ctrl i_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wsel[OFS_CTRL]),
    .rie_new (bus_wdata[C_RIE]),
    .wr_stat (wsel[OFS_STAT]),
    .wr_mpbt (bus_wdata[S_MPBT]),
    .wr_err  (bus_wdata[S_ELO +: EW]),
    .rd_stat (rsel[OFS_STAT]),
    .rd_rdat (rsel[OFS_RDAT]),
    .re      (ctrl_q[C_RE]),
    .rie     (ctrl_q[C_RIE]),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .rx_break(rx_break),
    .rdat_q  (rdat_q),
    .rx_full (rx_full),
    .err_q   (err_q),
    .mpbt_q  (mpbt_q),
    .irq_rx  (irq_rx),
    .irq_err (irq_err)
  );

  assign stat = {tx_empty, rx_full, err_q, tx_end, 1'b0, mpbt_q};

  always_comb begin
    unique case (ofs)
      OFS_MODE: bus_rdata = mode_q;
      OFS_RATE: bus_rdata = rate_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_TDAT: bus_rdata = tdat_q;
      OFS_STAT: bus_rdata = stat;
      OFS_RDAT: bus_rdata = rdat_q;
      OFS_SMC:  bus_rdata = smc_q;
      OFS_EXT:  bus_rdata = ext_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R3: enabling the transmitter leaves it empty and idle
  a_r3_te_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel[OFS_CTRL] && bus_wdata[C_TE]) |=> tx_empty && tx_end);
endmodule

// File: tb/test_sci_regif.sv
module test_sci_regif;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       tx_start, frame_done = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] tx_byte, rx_data = '0;
  logic       irq_tx, irq_tend, irq_rx, irq_err;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rv;

  always #4 clk = ~clk;

  sci_regif i_sci_regif (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every launch must match the next expected byte
  always @(negedge clk) begin
    if (rst_n && tx_start) begin
      if (exp_q.size() == 0) chk("R5 unexpected launch", tx_byte, 8'hxx);
      else chk("R4/R6 launched byte", tx_byte, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic send_tx(input logic [7:0] d);
    exp_q.push_back(d);
    wr(3, d);
  endtask

  task automatic fdone();
    @(negedge clk); frame_done = 1;
    @(negedge clk); frame_done = 0;
  endtask

  task automatic rxb(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    chk("R1 irqs", {4'b0, irq_tx, irq_tend, irq_rx, irq_err}, 8'h00);
    chk("R1 tx_start", {7'b0, tx_start}, 8'h00);
    rd(0, rv); chk("R1 mode", rv, 8'h00);
    rd(1, rv); chk("R1 rate", rv, 8'hFF);
    rd(2, rv); chk("R1 ctrl", rv, 8'h00);
    rd(3, rv); chk("R1 tdat", rv, 8'hFF);
    rd(4, rv); chk("R1 status", rv, 8'h84);
    rd(5, rv); chk("R1 rdat", rv, 8'h00);
    rd(6, rv); chk("R1 smc", rv, 8'h00);
    // R2 readback while unlocked
    wr(0, 8'h5A); rd(0, rv); chk("R2 mode", rv, 8'h5A);
    wr(1, 8'h12); rd(1, rv); chk("R2 rate", rv, 8'h12);
    wr(6, 8'h33); rd(6, rv); chk("R2 smc", rv, 8'h33);
    wr(7, 8'h11); rd(7, rv); chk("R2 ext", rv, 8'h11);
    // R3 transmit enable with TIE and TEIE
    wr(2, 8'hA4);
    chk("R3 irq_tx pulse", {7'b0, irq_tx}, 8'h01);
    rd(4, rv); chk("R3 status", rv, 8'h84);
    // R2 locked
    wr(0, 8'h00); rd(0, rv); chk("R2 mode locked", rv, 8'h5A);
    wr(1, 8'h00); rd(1, rv); chk("R2 rate locked", rv, 8'h12);
    // R4 immediate launch
    send_tx(8'h41);
    chk("R4 irq_tx", {7'b0, irq_tx}, 8'h01);
    chk("R4 tx_start", {7'b0, tx_start}, 8'h01);
    rd(4, rv); chk("R4 status", rv, 8'h80);
    // R5 queued
    wr(3, 8'h42);
    chk("R5 no launch", {7'b0, tx_start}, 8'h00);
    rd(4, rv); chk("R5 status", rv, 8'h00);
    // R6 chained launch
    exp_q.push_back(8'h42);
    fdone();
    chk("R6 chained start", {7'b0, tx_start}, 8'h01);
    rd(4, rv); chk("R6 status after chain", rv, 8'h80);
    fdone();
    chk("R6 irq_tend", {7'b0, irq_tend}, 8'h01);
    rd(4, rv); chk("R6 status idle", rv, 8'h84);
    send_tx(8'h43);
    chk("R4 irq_tend dropped", {7'b0, irq_tend}, 8'h00);
    fdone();
    chk("R6 irq_tend again", {7'b0, irq_tend}, 8'h01);
    wr(2, 8'hA0);
    chk("R11 teie cleared", {7'b0, irq_tend}, 8'h00);
    chk("R11 queue drained", exp_q.size(), 0);
    // R7 receive
    wr(2, 8'h50);
    rxb(8'h66);
    chk("R7 irq_rx", {7'b0, irq_rx}, 8'h01);
    rd(4, rv); chk("R7 status full", rv, 8'hC4);
    rd(5, rv); chk("R7 rdat", rv, 8'h66);
    rd(4, rv); chk("R8 read clears full", rv, 8'h84);
    // R8 overrun
    rxb(8'h01); rxb(8'h02);
    chk("R8 irq_err", {7'b0, irq_err}, 8'h01);
    rd(4, rv); chk("R8 status overrun", rv, 8'hE4);
    rd(5, rv); chk("R8 kept first", rv, 8'h01);
    rd(4, rv); chk("R8 status", rv, 8'hA4);
    // R9 clear by read then write
    wr(4, 8'h00);
    chk("R9 irq_err drop", {7'b0, irq_err}, 8'h00);
    rd(4, rv); chk("R9 status clear", rv, 8'h84);
    wr(4, 8'hFF); rd(4, rv); chk("R9 masked write", rv, 8'hBD);
    wr(4, 8'h00); rd(4, rv); chk("R9 cleared", rv, 8'h84);
    // R10 break
    @(negedge clk); rx_break = 1;
    @(negedge clk); rx_break = 0;
    chk("R10 irq_err", {7'b0, irq_err}, 8'h01);
    rd(4, rv); chk("R10 status", rv, 8'h94);
    wr(2, 8'h10);
    chk("R11 rie cleared", {7'b0, irq_err}, 8'h00);
    // R7 ignored without receive enable; R11 rdat write ignored
    wr(2, 8'h00);
    rxb(8'h77);
    chk("R7 no irq_rx", {7'b0, irq_rx}, 8'h00);
    rd(4, rv); chk("R7 ignored status", rv, 8'h94);
    wr(5, 8'h99); rd(5, rv); chk("R11 rdat write ignored", rv, 8'h01);
    wr(0, 8'h07); rd(0, rv); chk("R2 unlocked", rv, 8'h07);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule